// File: doc/BRIEF.md
# Flash Write-Completion Poller

This block sits on the host side of an 8-bit asynchronous parallel NOR flash bus. A separate command issuer writes the program or erase sequence. Once the final write strobe of that sequence has risen, the issuer pulses `start`. With that pulse it supplies the mode, the address to watch and the byte that should end up there (0xFF for an erase). The poller then runs timed read cycles at that address. It decides from one status bit whether the device is still working. While the device is busy, every other data bit is treated as meaningless. Before the poller releases the flash for new commands, it reports `done` or `error`.

There are two ways to detect completion. In complement mode, bit 7 of a read must equal bit 7 of the expected byte. In toggle mode, bit 6 must stop changing between two reads in a row. The device finishes asynchronously to the host clock, so a read can catch a half-settled value. For that reason, a status read that reports "finished" but does not return the exact expected byte is never taken as final. The poller makes two more reads at the same address and reports success only if both return the expected byte. A poll limit guards against a device that never finishes.

The controller states are as follows:
- `ST_IDLE` goes to `ST_POLL_GO` on `start`.
- `ST_POLL_GO` launches a read and goes to `ST_POLL_WAIT`.
- `ST_POLL_WAIT` leaves when a read completes:
  - to `ST_PASS` if the read shows finished and exact;
  - to `ST_CONF_GO` if it shows finished but inexact;
  - to `ST_FAIL` if it shows busy at the poll limit;
  - otherwise back to `ST_POLL_GO`.
- `ST_CONF_GO` launches a confirmation read and goes to `ST_CONF_WAIT`.
- `ST_CONF_WAIT` goes back to `ST_CONF_GO` after the first confirmation read. After the second, it goes to `ST_PASS` or `ST_FAIL`.
- `ST_PASS` and `ST_FAIL` both return to `ST_IDLE`.

Top module: `flash_wr_poller`

## Requirements
- R1: After reset, and whenever `busy` is low, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1, and no read happens before `start`.
- R2: Every read drives `mem_ce_n` and `mem_oe_n` low together for exactly ACC_CYC clock cycles. During the read, `mem_we_n` is 1 and `mem_addr` equals the latched address. Each read is followed by at least one cycle with both strobes high.
- R3: A `start` pulse while idle latches `start_toggle`, `start_addr` and `start_data` and raises `busy`. A `start` pulse while `busy` is high has no effect on the address read, the number of reads or the result.
- R4: In complement mode (`start_toggle`=0), a status read counts as finished when data bit 7 equals bit 7 of the expected byte. Bits 6..0 of a read that is not finished have no effect.
- R5: In toggle mode (`start_toggle`=1), a status read counts as finished when its data bit 6 equals bit 6 of the previous status read. The first read of an operation never counts as finished.
- R6: If a finished status read returns exactly the expected byte, `done` pulses and no further read is made.
- R7: If a finished status read differs from the expected byte, exactly two confirmation reads follow at the same address. `done` pulses if both return the expected byte.
- R8: If either confirmation read differs from the expected byte, `error` pulses after the second confirmation read.
- R9: If status read number MAX_POLLS is not finished, `error` pulses and no further read is made.
- R10: A status read that finishes on read number MAX_POLLS follows R6 to R8; it is not reported as a timeout.
- R11: `done` and `error` are single-cycle pulses issued in the last cycle of `busy`, never both at once. `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling (accepted only while idle) |
| start_toggle | input | 1 | 1 = toggle-bit mode, 0 = complement mode |
| start_addr | input | AW | Address to poll |
| start_data | input | 8 | Expected final byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Pulse: write confirmed complete |
| error | output | 1 | Pulse: timeout or confirmed rejection |
| mem_addr | output | AW | Flash address bus |
| mem_dq_in | input | 8 | Flash read data |
| mem_ce_n | output | 1 | Flash chip enable, active low |
| mem_oe_n | output | 1 | Flash output enable, active low |
| mem_we_n | output | 1 | Flash write enable, active low (held high) |

## Verification
Two events can fall on the same status read. One is the poll limit running out. The other is the device reporting completion, either on that same read or on a half-settled read that leads into confirmation. The bench provokes this in both modes by making the simulated device finish exactly on read number MAX_POLLS. It expects a `done` after that read count, not a timeout `error`. Separate cases place an inexact finishing read at the end of the busy period, with the confirmation reads both good or both bad. Each expected result and read count comes from a reference walk of the device stub through the rules above.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_POLL_GO   = 3'd1,
        ST_POLL_WAIT = 3'd2,
        ST_CONF_GO   = 3'd3,
        ST_CONF_WAIT = 3'd4,
        ST_PASS      = 3'd5,
        ST_FAIL      = 3'd6
    } fpoll_state_e;

    typedef enum logic {
        MODE_COMPL  = 1'b0,
        MODE_TOGGLE = 1'b1
    } fpoll_mode_e;

    localparam int COMPL_BIT  = 7;
    localparam int TOGGLE_BIT = 6;

endpackage

// File: rtl/fpoll_bus_rd.sv
module fpoll_bus_rd #(
    parameter int AW      = 17,
    parameter int ACC_CYC = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_go,
    input  logic [AW-1:0] rd_addr,
    input  logic [7:0]    dq_in,
    output logic          rd_done,
    output logic [7:0]    rd_data,
    output logic          rd_idle,
    output logic [AW-1:0] mem_addr,
    output logic          ce_n,
    output logic          oe_n
);
    localparam int CW = (ACC_CYC < 2) ? 1 : $clog2(ACC_CYC);

    typedef enum logic {B_IDLE, B_ACT} bus_state_e;

    bus_state_e    bst_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bst_q    <= B_IDLE;
            cnt_q    <= '0;
            ce_n     <= 1'b1;
            oe_n     <= 1'b1;
            rd_done  <= 1'b0;
            rd_data  <= '0;
            mem_addr <= '0;
        end else begin
            rd_done <= 1'b0;
            unique case (bst_q)
                B_IDLE: begin
                    if (rd_go) begin
                        ce_n     <= 1'b0;
                        oe_n     <= 1'b0;
                        mem_addr <= rd_addr;
                        cnt_q    <= CW'(ACC_CYC - 1);
                        bst_q    <= B_ACT;
                    end
                end
                B_ACT: begin
                    if (cnt_q == '0) begin
                        rd_data <= dq_in;
                        ce_n    <= 1'b1;
                        oe_n    <= 1'b1;
                        rd_done <= 1'b1;
                        bst_q   <= B_IDLE;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                default: bst_q <= B_IDLE;
            endcase
        end
    end

    assign rd_idle = (bst_q == B_IDLE);

    // R2
    strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n == oe_n);

    // R2
    go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |-> rd_idle);

    // R2
    recovery_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |=> oe_n);

endmodule

// File: rtl/fpoll_judge.sv
module fpoll_judge
    import fpoll_pkg::*;
(
    input  fpoll_mode_e mode,
    input  logic [7:0]  exp_byte,
    input  logic [7:0]  cur,
    input  logic        prev_b6,
    input  logic        prev_vld,
    output logic        finished,
    output logic        exact
);
    always_comb begin
        unique case (mode)
            MODE_COMPL:  finished = (cur[COMPL_BIT] == exp_byte[COMPL_BIT]);
            MODE_TOGGLE: finished = prev_vld && (cur[TOGGLE_BIT] == prev_b6);
            default:     finished = 1'b0;
        endcase
        exact = (cur == exp_byte);
    end
endmodule

// File: rtl/fpoll_poll_cnt.sv
module fpoll_poll_cnt #(
    parameter int MAX_POLLS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + PW'(1);
    end

    assign at_limit = (cnt_q == PW'(MAX_POLLS - 1));

    // R9
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= PW'(MAX_POLLS));

endmodule

// File: rtl/flash_wr_poller.sv
module flash_wr_poller
    import fpoll_pkg::*;
#(
    parameter int AW        = 17,
    parameter int ACC_CYC   = 18,
    parameter int MAX_POLLS = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_toggle,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    start_data,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_dq_in,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n
);
    fpoll_state_e  st_q, st_d;
    fpoll_mode_e   mode_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    exp_q;
    logic          prev_b6_q, prev_vld_q;
    logic          conf_idx_q, conf_ok_q;

    logic          rd_go, rd_done, rd_idle;
    logic [7:0]    rd_data;
    logic          finished, exact, at_limit;
    logic          accept, poll_done;

    assign accept    = (st_q == ST_IDLE) && start;
    assign poll_done = (st_q == ST_POLL_WAIT) && rd_done;
    assign rd_go     = (st_q == ST_POLL_GO) || (st_q == ST_CONF_GO);

    fpoll_bus_rd #(.AW(AW), .ACC_CYC(ACC_CYC)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_go    (rd_go),
        .rd_addr  (addr_q),
        .dq_in    (mem_dq_in),
        .rd_done  (rd_done),
        .rd_data  (rd_data),
        .rd_idle  (rd_idle),
        .mem_addr (mem_addr),
        .ce_n     (mem_ce_n),
        .oe_n     (mem_oe_n)
    );

    fpoll_judge u_judge (
        .mode     (mode_q),
        .exp_byte (exp_q),
        .cur      (rd_data),
        .prev_b6  (prev_b6_q),
        .prev_vld (prev_vld_q),
        .finished (finished),
        .exact    (exact)
    );

    fpoll_poll_cnt #(.MAX_POLLS(MAX_POLLS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .inc      (poll_done),
        .at_limit (at_limit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (start) st_d = ST_POLL_GO;
            ST_POLL_GO:   st_d = ST_POLL_WAIT;
            ST_POLL_WAIT: begin
                if (rd_done) begin
                    if (finished)      st_d = exact ? ST_PASS : ST_CONF_GO;
                    else if (at_limit) st_d = ST_FAIL;
                    else               st_d = ST_POLL_GO;
                end
            end
            ST_CONF_GO:   st_d = ST_CONF_WAIT;
            ST_CONF_WAIT: begin
                if (rd_done) begin
                    if (!conf_idx_q)                        st_d = ST_CONF_GO;
                    else if (conf_ok_q && rd_data == exp_q) st_d = ST_PASS;
                    else                                    st_d = ST_FAIL;
                end
            end
            ST_PASS:      st_d = ST_IDLE;
            ST_FAIL:      st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    // Operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_COMPL;
            addr_q     <= '0;
            exp_q      <= '0;
            prev_b6_q  <= 1'b0;
            prev_vld_q <= 1'b0;
            conf_idx_q <= 1'b0;
            conf_ok_q  <= 1'b0;
        end else begin
            if (accept) begin
                mode_q     <= start_toggle ? MODE_TOGGLE : MODE_COMPL;
                addr_q     <= start_addr;
                exp_q      <= start_data;
                prev_vld_q <= 1'b0;
            end
            if (poll_done) begin
                prev_b6_q  <= rd_data[TOGGLE_BIT];
                prev_vld_q <= 1'b1;
                conf_idx_q <= 1'b0;
                conf_ok_q  <= 1'b1;
            end
            if ((st_q == ST_CONF_WAIT) && rd_done) begin
                conf_idx_q <= 1'b1;
                conf_ok_q  <= conf_ok_q && (rd_data == exp_q);
            end
        end
    end

    // Outputs
    always_comb begin
        busy     = (st_q != ST_IDLE);
        done     = (st_q == ST_PASS);
        error    = (st_q == ST_FAIL);
        mem_we_n = 1'b1;
    end

    // R1
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce_n && mem_oe_n));

    // R2
    addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_addr == addr_q));

    // R3
    busy_start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(addr_q) && $stable(exp_q) && $stable(mode_q));

    // R6
    no_read_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> (rd_idle && mem_oe_n));

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R11
    pulse_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |=> !busy && !done && !error);

endmodule

// File: tb/flash_wr_poller_tb.sv
module flash_wr_poller_tb;
    localparam int AW        = 17;
    localparam int ACC_CYC   = 18;
    localparam int MAX_POLLS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          start_toggle = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [7:0]    start_data = '0;
    logic          busy, done, error;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_dq_in;
    logic          mem_ce_n, mem_oe_n, mem_we_n;

    always #2 clk = ~clk;

    flash_wr_poller #(.AW(AW), .ACC_CYC(ACC_CYC), .MAX_POLLS(MAX_POLLS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_toggle(start_toggle),
        .start_addr(start_addr), .start_data(start_data), .busy(busy),
        .done(done), .error(error), .mem_addr(mem_addr), .mem_dq_in(mem_dq_in),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Device stub configuration
    int         cfg_n = 0;
    logic [7:0] cfg_exp = '0;
    bit         cfg_glitch = 0;
    bit         cfg_bad = 0;
    int         rd_idx = 0;
    logic [AW-1:0] cur_addr = '0;

    function automatic logic [7:0] dev_val(input int idx);
        logic [7:0] v;
        logic       pb6;
        if (idx < cfg_n) begin
            v = {~cfg_exp[7], idx[0], 6'(idx * 5 + 3)};
        end else if (idx == cfg_n && cfg_glitch) begin
            pb6 = (cfg_n > 0) ? idx[0] ^ 1'b1 : cfg_exp[6];
            v = {cfg_exp[7], pb6, cfg_exp[5:0] ^ 6'h03};
        end else begin
            v = cfg_bad ? (cfg_exp ^ 8'h11) : cfg_exp;
        end
        return v;
    endfunction

    assign mem_dq_in = dev_val(rd_idx);

    // Reference walk through R4..R10
    typedef struct { bit ok; int reads; } exp_t;
    exp_t sbq[$];

    function automatic exp_t model(input bit tgl);
        exp_t r;
        logic [7:0] v, p;
        bit have, fin;
        int n;
        have = 0; n = 0; p = '0;
        r.ok = 0; r.reads = 0;
        forever begin
            v = dev_val(n);
            n++;
            fin = tgl ? (have && v[6] == p[6]) : (v[7] == cfg_exp[7]);
            if (fin) begin
                if (v == cfg_exp) r.ok = 1;
                else r.ok = (dev_val(n) == cfg_exp) && (dev_val(n + 1) == cfg_exp);
                if (v != cfg_exp) n += 2;
                r.reads = n;
                return r;
            end
            if (n >= MAX_POLLS) begin
                r.ok = 0; r.reads = n;
                return r;
            end
            p = v; have = 1;
        end
    endfunction

    // Bus monitor
    logic oe_prev = 1'b1;
    int   low_len = 0;
    int   bus_bad = 0;
    int   width_bad = 0;
    int   gap_bad = 0;
    int   pulse_bad = 0;
    int   idle_bad = 0;
    bit   op_end = 0;
    bit   end_busy_low = 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_ce_n != mem_oe_n || mem_we_n != 1'b1) bus_bad++;
            if (!mem_oe_n && mem_addr != cur_addr) bus_bad++;
            if (!busy && (!mem_ce_n || !mem_oe_n || !mem_we_n)) idle_bad++;
            if (done && error) pulse_bad++;
            if (!mem_oe_n) low_len++;
            if (oe_prev == 1'b0 && mem_oe_n == 1'b1) begin
                if (low_len != ACC_CYC) width_bad++;
                low_len = 0;
                rd_idx++;
            end
            if (oe_prev == 1'b1 && mem_oe_n == 1'b0 && rd_idx > 0 && low_len != 1) gap_bad++;
            oe_prev = mem_oe_n;
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (done || error)) begin
            exp_t e;
            if (sbq.size() == 0) begin
                check(0, "R11", "unexpected result pulse", 1, 0);
            end else begin
                e = sbq.pop_front();
                check(done == e.ok && error == !e.ok, e.ok ? "R6" : "R8",
                      "result done", int'(done), int'(e.ok));
                check(rd_idx == e.reads, "R7", "read count", rd_idx, e.reads);
                check(busy == 1'b1, "R11", "busy in pulse cycle", int'(busy), 1);
            end
            op_end = 1;
        end
    end

    task automatic run_op(input bit tgl, input logic [7:0] ev, input int n,
                          input bit gl, input bit bad, input logic [AW-1:0] a,
                          input bit poke, input string req);
        exp_t e;
        int w;
        cfg_n = n; cfg_exp = ev; cfg_glitch = gl; cfg_bad = bad;
        e = model(tgl);
        sbq.push_back(e);
        @(negedge clk);
        rd_idx = 0; cur_addr = a; op_end = 0;
        start = 1; start_toggle = tgl; start_addr = a; start_data = ev;
        @(negedge clk);
        start = 0;
        check(busy == 1'b1, req, "busy after start", int'(busy), 1);
        if (poke) begin
            repeat (30) @(negedge clk);
            start = 1; start_toggle = ~tgl; start_addr = a ^ 17'h1F0F0;
            start_data = ~ev;
            @(negedge clk);
            start = 0;
        end
        w = 0;
        while (!op_end && w < 5000) begin
            @(negedge clk);
            w++;
        end
        check(op_end, req, "operation ended", int'(op_end), 1);
        @(negedge clk);
        check(busy == 1'b0, "R11", "busy low after pulse", int'(busy), 0);
        repeat (3) @(negedge clk);
        check(rd_idx == e.reads, req, "no extra reads", rd_idx, e.reads);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes in reset",
              int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
        rst_n = 1;
        repeat (5) @(negedge clk);
        check(!busy && !done && !error, "R1", "status after reset",
              int'({busy, done, error}), 0);
        check(rd_idx == 0, "R1", "no read before start", rd_idx, 0);

        run_op(0, 8'hA5, 5, 0, 0, 17'h00123, 0, "R4");   // R4 complement
        run_op(0, 8'h3C, 0, 0, 0, 17'h1FFFF, 0, "R4");   // R4 immediate
        run_op(1, 8'h5A, 6, 0, 0, 17'h00400, 1, "R3");   // R3 start while busy, R5
        run_op(1, 8'h00, 3, 0, 0, 17'h0ABCD, 0, "R5");   // R5 toggle
        run_op(1, 8'h42, 0, 0, 0, 17'h00001, 0, "R5");   // R5 first read never final
        run_op(0, 8'hFF, 6, 0, 0, 17'h10000, 0, "R6");   // R6 erase value
        run_op(0, 8'h81, 4, 1, 0, 17'h00777, 0, "R7");   // R7 confirm good
        run_op(1, 8'h6E, 5, 1, 0, 17'h01234, 0, "R7");   // R7 toggle confirm good
        run_op(0, 8'hC3, 3, 0, 1, 17'h05555, 0, "R8");   // R8 rejection
        run_op(1, 8'h42, 2, 1, 1, 17'h0AAAA, 0, "R8");   // R8 toggle rejection
        run_op(0, 8'h12, 20, 0, 0, 17'h00F00, 0, "R9");  // R9 timeout
        run_op(1, 8'h12, 20, 0, 0, 17'h00F01, 0, "R9");  // R9 toggle timeout
        run_op(0, 8'h99, 7, 0, 0, 17'h00002, 0, "R10");  // R10 finish on last poll
        run_op(1, 8'h80, 7, 0, 0, 17'h00003, 0, "R10");  // R10 toggle, last poll
        run_op(0, 8'h5A, 7, 1, 0, 17'h00004, 0, "R10");  // R10 glitch on last poll

        check(bus_bad == 0, "R2", "strobe/address violations", bus_bad, 0);
        check(width_bad == 0, "R2", "read pulse width errors", width_bad, 0);
        check(gap_bad == 0, "R2", "missing recovery gap", gap_bad, 0);
        check(idle_bad == 0, "R1", "strobes active while idle", idle_bad, 0);
        check(pulse_bad == 0, "R11", "done and error together", pulse_bad, 0);
        check(sbq.size() == 0, "R11", "results outstanding", sbq.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule